// File: doc/BRIEF.md
# Down-Counting PWM Timer Channel

This block is a single timer channel that produces one pulse-width-modulated output pin from a 32-bit down-counter. Software writes a period value and a compare value into two buffer registers. These values reach the running counter and comparator only when the channel reloads. A reload happens in one of two ways: software holds a manual-update bit, or the counter reaches zero while auto-reload is enabled.

A tick-enable generator sets the counting rate. It divides the clock by an 8-bit prescaler plus one and then by a power of two. The counter value can be read at any time, so the channel also works as a free-running countdown timer when it is loaded with all ones.

Register writes use a simple write strobe with a 2-bit address:
- Address 0 is the period buffer.
- Address 1 is the compare buffer.
- Address 2 is the control word.
- Address 3 is the clock configuration.

Top module: `pwm_timer_chan`

## Requirements
- R1: A synchronous active-low reset clears the following: the counter, the active compare, both buffers, the control word, the clock configuration and the output level. After reset, `countNow` reads 0 and `pwmOut` is low.
- R2: Writing address 3 sets the prescaler P (bits 7:0) and the divider select S (bits 11:8). While the start bit is set, the counter decrements by exactly one every (P+1)·2^S clock cycles.
- R3: In the control word, bit 1 is manual update. On every clock edge while this bit is set, the active counter takes the period buffer (address 0) and the active compare takes the compare buffer (address 1). The output level is forced low, and counting ticks are suppressed.
- R4: A write to either buffer leaves the active counter and the active compare unchanged until the next reload.
- R5: In the control word, bit 3 is auto-reload. With this bit set, a tick that finds the counter at zero reloads the counter and the compare from the buffers and drives the output level low.
- R6: With auto-reload clear, the counter stays at zero once it gets there.
- R7: The output level goes high on the tick whose decremented count equals the active compare. It never goes high at any other time, so a compare equal to or above the loaded count gives a constantly low output.
- R8: In the control word, bit 2 inverts the `pwmOut` pin relative to the output level.
- R9: In the control word, bit 0 is start. While this bit is clear and manual update is clear, the counter holds its value.
- R10: `countNow` always shows the live counter. When the counter is loaded with all ones and auto-reload is set, it counts down continuously from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (0 period, 1 compare, 2 control, 3 clock config) |
| wrData | input | 32 | Write data |
| countNow | output | 32 | Live counter value |
| pwmOut | output | 1 | PWM output pin |

## Verification
The assertions assume that the control word is held stable by register writes alone and that the buffers are written only through the write port. They also assume that the prescaler and divider settings take effect on the clock after they are written.

The stimulus writes only the four defined addresses. Its random phase uses small period and compare values and small prescaler and divider settings. This keeps reloads, compare matches and stop-at-zero events frequent within the run. Manual update is drawn rarely, so that counting phases last long enough to reach zero.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;   // manual update active
    logic step;   // decrement tick
    logic rearm;  // auto-reload enabled
  } pwmt_strobe_t;

  localparam int ADDR_PERIOD = 0;
  localparam int ADDR_COMPARE = 1;
  localparam int ADDR_CTRL = 2;
  localparam int ADDR_CLKCFG = 3;
endpackage

// File: rtl/pwmt_tick.sv
module pwmt_tick #(
  parameter int PSC_W = 8,
  parameter int DSEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [PSC_W-1:0]  presc,
  input  logic [DSEL_W-1:0] divSel,
  output logic              tick
);
  localparam int DCNT_W = 2 ** DSEL_W;

  logic [PSC_W-1:0]  preCnt;
  logic [DCNT_W-1:0] divCnt;
  logic [DCNT_W-1:0] divMask;
  logic              preWrap;

  always_comb begin
    divMask = (DCNT_W'(1) << divSel) - DCNT_W'(1);
    preWrap = (preCnt == presc);
    tick    = run && preWrap && ((divCnt & divMask) == divMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      divCnt <= divCnt + DCNT_W'(1);
    end else begin
      preCnt <= preCnt + PSC_W'(1);
    end
  end
endmodule

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 8,
  parameter int DSEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output pwmt_strobe_t     strobe,
  output logic [CNT_W-1:0] cntBuf,
  output logic [CNT_W-1:0] cmpBuf,
  output logic             invert
);
  logic              ctlStart, ctlManual, ctlAuto;
  logic [PSC_W-1:0]  presc;
  logic [DSEL_W-1:0] divSel;
  logic              tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntBuf    <= '0;
      cmpBuf    <= '0;
      ctlStart  <= 1'b0;
      ctlManual <= 1'b0;
      invert    <= 1'b0;
      ctlAuto   <= 1'b0;
      presc     <= '0;
      divSel    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'(ADDR_PERIOD):  cntBuf <= wrData;
        2'(ADDR_COMPARE): cmpBuf <= wrData;
        2'(ADDR_CTRL): begin
          ctlStart  <= wrData[0];
          ctlManual <= wrData[1];
          invert    <= wrData[2];
          ctlAuto   <= wrData[3];
        end
        default: begin
          presc  <= wrData[PSC_W-1:0];
          divSel <= wrData[PSC_W +: DSEL_W];
        end
      endcase
    end
  end

  pwmt_tick #(.PSC_W(PSC_W), .DSEL_W(DSEL_W)) uTick (
    .clk(clk), .rstN(rstN), .run(ctlStart),
    .presc(presc), .divSel(divSel), .tick(tick)
  );

  always_comb begin
    strobe.load  = ctlManual;
    strobe.step  = tick && !ctlManual;
    strobe.rearm = ctlAuto;
  end
endmodule

// File: rtl/pwmt_dpath.sv
module pwmt_dpath
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmt_strobe_t     strobe,
  input  logic [CNT_W-1:0] cntBuf,
  input  logic [CNT_W-1:0] cmpBuf,
  output logic [CNT_W-1:0] cnt,
  output logic             outLvl
);
  logic [CNT_W-1:0] cmpAct;
  logic [CNT_W-1:0] cntDec;
  logic             atZero;

  always_comb begin
    cntDec = cnt - CNT_W'(1);
    atZero = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      cmpAct <= '0;
      outLvl <= 1'b0;
    end else if (strobe.load) begin
      cnt    <= cntBuf;
      cmpAct <= cmpBuf;
      outLvl <= 1'b0;
    end else if (strobe.step) begin
      if (!atZero) begin
        cnt <= cntDec;
        if (cntDec == cmpAct) outLvl <= 1'b1;
      end else if (strobe.rearm) begin
        cnt    <= cntBuf;
        cmpAct <= cmpBuf;
        outLvl <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 8,
  parameter int DSEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countNow,
  output logic             pwmOut
);
  pwmt_strobe_t     strobe;
  logic [CNT_W-1:0] cntBuf, cmpBuf;
  logic             invert, outLvl;

  pwmt_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DSEL_W(DSEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cntBuf(cntBuf), .cmpBuf(cmpBuf), .invert(invert)
  );

  pwmt_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntBuf(cntBuf), .cmpBuf(cmpBuf),
    .cnt(countNow), .outLvl(outLvl)
  );

  assign pwmOut = outLvl ^ invert;
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input pwmt_strobe_t     strobe,
  input logic [CNT_W-1:0] cntBuf,
  input logic [CNT_W-1:0] countNow,
  input logic             outLvl
);
  // R3
  manual_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> countNow == $past(cntBuf));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(countNow));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && strobe.step && countNow != '0) |=> countNow == $past(countNow) - CNT_W'(1));

  // R6
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.rearm && countNow == '0) |=> countNow == '0);

  // R7
  rise_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outLvl) |-> $past(strobe.step));
endmodule

bind pwm_timer_chan pwmt_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .cntBuf(cntBuf),
  .countNow(countNow), .outLvl(outLvl)
);

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [1:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] countNow;
  logic        pwmOut;

  int  nChk = 0, nBad = 0;
  bit  cmpOn = 0, done = 0;
  string tag = "R2";

  pwm_timer_chan u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                     .wrData(wrData), .countNow(countNow), .pwmOut(pwmOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic [31:0] mCnt, mCmp, mCntBuf, mCmpBuf;
  logic [7:0]  mPre, mPsc;
  logic [15:0] mDiv;
  logic [3:0]  mDsel;
  logic        mStart, mMan, mInv, mAuto, mLvl;

  function automatic logic tickDue(logic st, logic [7:0] pre, logic [7:0] psc,
                                   logic [15:0] dv, logic [3:0] ds);
    logic [15:0] m;
    m = (16'd1 << ds) - 16'd1;
    return st && (pre == psc) && ((dv & m) == m);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mCntBuf = 0; mCmpBuf = 0; mPre = 0; mPsc = 0;
      mDiv = 0; mDsel = 0; mStart = 0; mMan = 0; mInv = 0; mAuto = 0; mLvl = 0;
    end else begin
      logic tk;
      tk = tickDue(mStart, mPre, mPsc, mDiv, mDsel);
      if (mMan) begin
        mCnt = mCntBuf; mCmp = mCmpBuf; mLvl = 0;
      end else if (tk) begin
        if (mCnt != 0) begin
          mCnt = mCnt - 1;
          if (mCnt == mCmp) mLvl = 1;
        end else if (mAuto) begin
          mCnt = mCntBuf; mCmp = mCmpBuf; mLvl = 0;
        end
      end
      if (!mStart) begin mPre = 0; mDiv = 0; end
      else if (mPre == mPsc) begin mPre = 0; mDiv = mDiv + 1; end
      else mPre = mPre + 1;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mCntBuf = wrData;
          2'd1: mCmpBuf = wrData;
          2'd2: begin mStart = wrData[0]; mMan = wrData[1]; mInv = wrData[2]; mAuto = wrData[3]; end
          default: begin mPsc = wrData[7:0]; mDsel = wrData[11:8]; end
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      check({tag, " count"}, countNow, mCnt);
      check({tag, " pin"}, {31'd0, pwmOut}, {31'd0, mLvl ^ mInv});
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitCount(logic [31:0] v);
    for (int i = 0; i < 2000 && countNow !== v; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    int gap;
    bit sawHigh;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", countNow, 0);
    check("R1 pin", {31'd0, pwmOut}, 0);
    cmpOn = 1;

    // R3 manual load, then R7/R5 with a fast tick
    tag = "R3";
    wr(0, 10); wr(1, 4); wr(2, 32'b1010);
    @(negedge clk);
    check("R3 manual load", countNow, 10);
    tag = "R7";
    wr(2, 32'b1001);
    waitCount(4);
    check("R7 rise at match", {31'd0, pwmOut}, 1);
    waitCount(0);
    check("R7 high until zero", {31'd0, pwmOut}, 1);
    @(negedge clk);
    check("R5 reload value", countNow, 10);
    check("R5 level low after reload", {31'd0, pwmOut}, 0);

    // R4 buffer change mid-period
    tag = "R4";
    wr(0, 50);
    check("R4 active count unchanged", {31'd0, countNow <= 10}, 1);
    waitCount(0);
    @(negedge clk);
    check("R4 new period after reload", countNow, 50);

    // R9 halt
    tag = "R9";
    wr(2, 32'b1000);
    held = countNow;
    repeat (20) @(negedge clk);
    check("R9 held while stopped", countNow, held);

    // R6 stop at zero, compare above count never rises (R7)
    tag = "R6";
    wr(0, 5); wr(1, 7); wr(2, 32'b0010); wr(2, 32'b0001);
    repeat (30) @(negedge clk);
    check("R6 parked at zero", countNow, 0);
    check("R7 compare above count stays low", {31'd0, pwmOut}, 0);

    // R7 compare equal to count never toggles
    tag = "R7";
    wr(0, 6); wr(1, 6); wr(2, 32'b0010); wr(2, 32'b1001);
    sawHigh = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwmOut) sawHigh = 1; end
    check("R7 equal compare never high", {31'd0, sawHigh}, 0);

    // R8 invert
    tag = "R8";
    wr(2, 32'b0110);
    @(negedge clk);
    check("R8 inverted low level", {31'd0, pwmOut}, 1);

    // R2 tick rate: prescaler 2, divider 2 -> 6 clocks per step
    tag = "R2";
    wr(3, (32'd1 << 8) | 32'd2);
    wr(0, 1000); wr(2, 32'b0010); wr(2, 32'b1001);
    held = countNow;
    for (int i = 0; i < 100 && countNow == held; i++) @(negedge clk);
    held = countNow; gap = 0;
    for (int i = 0; i < 100 && countNow == held; i++) begin @(negedge clk); gap++; end
    check("R2 clocks per step", gap, 6);

    // R10 free-running countdown from all ones
    tag = "R10";
    wr(3, 0); wr(0, 32'hFFFF_FFFF); wr(2, 32'b1010);
    @(negedge clk);
    check("R10 all ones loaded", countNow, 32'hFFFF_FFFF);
    wr(2, 32'b1001);
    repeat (10) @(negedge clk);
    check("R10 still counting near top", {31'd0, countNow > 32'hFFFF_FF00 && countNow < 32'hFFFF_FFFF}, 1);

    // random phase
    tag = "R2";
    for (int i = 0; i < 1500; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 2) wr(0, $urandom_range(0, 40));
      else if (sel < 4) wr(1, $urandom_range(0, 45));
      else if (sel < 6) begin
        logic [3:0] c = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 7) != 0) c[1] = 0;
        wr(2, {28'd0, c});
      end else if (sel == 6) wr(3, {20'd0, 4'($urandom_range(0, 2)), 8'($urandom_range(0, 3))});
      else repeat ($urandom_range(1, 12)) @(negedge clk);
    end
    finishRun();
  end
endmodule